// File: doc/BRIEF.md
# Reloadable Programmable Frequency Divider

This block divides a clock by a programmable integer and emits a one-clock pulse once per division period. In a frequency synthesizer two copies of it sit in front of the phase detector. One divides the reference oscillator down to the comparison rate. The other divides the output of a dual-modulus prescaler, which is where the VCO signal ends up. The pulse from each copy is what the phase detector compares.

A new divide value arrives on `div_value` together with a one-cycle `load_stb`. The value is always captured into a shadow register. How it reaches the running down-counter depends on `force_mode`:

- **Deferred reload** (`force_mode` = 0): the current period finishes undisturbed. The new value is used the next time the counter passes through zero.
- **Forced reload** (`force_mode` = 1): the counter restarts from the new value on the same clock edge that latches it. This shortens settling after a band change.

While `pd_n` is low, the block is in powerdown. The counter is parked at its reload value and no pulse is produced.

Top module: `prog_div`

## Requirements
- R1: After reset is released, `tc_pulse` is low and the divider runs with the divide value RESET_DIV (default 10). The first pulse appears on the RESET_DIV-1'th rising edge after release.
- R2: With a steady divide value N, where 2 ≤ N ≤ 2047, consecutive `tc_pulse` assertions are exactly N rising edges apart.
- R3: `tc_pulse` is high for exactly one clock cycle per period. It is never high on two consecutive cycles.
- R4: A value latched with `force_mode` = 0 does not change the period in progress. The following period uses the new value.
- R5: If several values are latched with `force_mode` = 0 inside one period, only the last one takes effect at the next reload.
- R6: A value N latched with `force_mode` = 1 reloads the counter on the latch edge. The next pulse comes N-1 edges later, and the period is N from then on.
- R7: A written value of 0 or 1 is taken as 2, so the output toggles every other cycle and never sticks high.
- R8: While `pd_n` is 0, `tc_pulse` stays low and the counter is held at the newest latched value. After `pd_n` returns to 1, the first pulse comes N-1 edges later.
- R9: The full 11-bit value 2047 gives a period of 2047 edges.
- R10: A value latched with `force_mode` = 0 on the very cycle the counter is at zero is used for the reload on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low powerdown; low parks the counter and silences the output |
| div_value | input | 11 | New divide value, captured while `load_stb` is high |
| load_stb | input | 1 | One-cycle strobe that latches `div_value` |
| force_mode | input | 1 | 1 = reload the counter on the latch edge; 0 = reload only at terminal count |
| tc_pulse | output | 1 | One-cycle terminal-count pulse, once per period |

## Verification
The divider is run with several steady divide values: the reset default, a small odd value, the clamped values 0 and 1, and the full-scale 2047. Each one checks that the pulse spacing equals the programmed ratio.

Writes are placed at four points in the period: well before the end, twice within one period, exactly on the terminal cycle, and during powerdown. Comparing the first pulse after each write with the spacing that follows separates three behaviours: a deferred reload, a forced reload, and a write that was wrongly ignored or applied too early. The powerdown stretch confirms that the output stays silent and that counting restarts from the newest value.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic {
      RELOAD_AT_TC   = 1'b0,
      RELOAD_ON_LOAD = 1'b1
   } reload_mode_e;

   typedef enum logic [1:0] {
      CNT_PARK,
      CNT_FORCE,
      CNT_WRAP,
      CNT_STEP
   } cnt_action_e;
endpackage

// File: rtl/div_clamp.sv
module div_clamp #(
   parameter int W       = 11,
   parameter int MIN_DIV = 2
) (
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] val_o
);
   localparam logic [W-1:0] MIN_V = W'(MIN_DIV);

   generate
      if (MIN_DIV < 2 || MIN_DIV >= (1 << W)) begin : g_bad_min
         $error("div_clamp: MIN_DIV out of range");
      end
   endgenerate

   always_comb begin
      if (raw_i < MIN_V) val_o = MIN_V;
      else               val_o = raw_i;
   end
endmodule

// File: rtl/div_shadow.sv
module div_shadow #(
   parameter int W         = 11,
   parameter int RESET_DIV = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] shadow_o,
   output logic [W-1:0] newest_o
);
   localparam logic [W-1:0] RST_V = W'(RESET_DIV);

   logic [W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow_q <= RST_V;
      else if (wr_i) shadow_q <= din_i;
   end

   // A write in this very cycle must win over the stored value.
   assign newest_o = wr_i ? din_i : shadow_q;
   assign shadow_o = shadow_q;
endmodule

// File: rtl/div_counter.sv
module div_counter
   import div_pkg::*;
#(
   parameter int W         = 11,
   parameter int RESET_DIV = 10,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         force_i,
   input  logic [W-1:0] force_val_i,
   input  logic [W-1:0] reload_val_i,
   output logic [W-1:0] count_o,
   output logic         tc_o
);
   localparam logic [W-1:0] ONE   = W'(1);
   localparam logic [W-1:0] RST_C = W'(RESET_DIV - 1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         at_zero;
   logic         tc_raw;
   cnt_action_e  act;

   assign at_zero = (cnt_q == '0);

   always_comb begin
      if (!run_i)       act = CNT_PARK;
      else if (force_i) act = CNT_FORCE;
      else if (at_zero) act = CNT_WRAP;
      else              act = CNT_STEP;
   end

   always_comb begin
      unique case (act)
         CNT_PARK:  cnt_d = reload_val_i - ONE;
         CNT_FORCE: cnt_d = force_val_i - ONE;
         CNT_WRAP:  cnt_d = reload_val_i - ONE;
         default:   cnt_d = cnt_q - ONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RST_C;
      else        cnt_q <= cnt_d;
   end

   assign tc_raw  = run_i && at_zero;
   assign count_o = cnt_q;

   generate
      if (OUT_REG) begin : g_tc_flop
         logic tc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tc_q <= 1'b0;
            else        tc_q <= tc_raw;
         end
         assign tc_o = tc_q;
      end else begin : g_tc_comb
         assign tc_o = tc_raw;
      end
   endgenerate
endmodule

// File: rtl/prog_div.sv
module prog_div
   import div_pkg::*;
#(
   parameter int DIV_W     = 11,
   parameter int RESET_DIV = 10,
   parameter int MIN_DIV   = 2,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic [DIV_W-1:0] div_value,
   input  logic             load_stb,
   input  logic             force_mode,
   output logic             tc_pulse
);
   generate
      if (DIV_W < 2 || DIV_W > 24) begin : g_bad_w
         $error("prog_div: DIV_W out of range");
      end
      if (RESET_DIV < MIN_DIV || RESET_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("prog_div: RESET_DIV out of range");
      end
   endgenerate

   logic [DIV_W-1:0] din_clamped;
   logic [DIV_W-1:0] shadow_q;
   logic [DIV_W-1:0] newest_val;
   logic [DIV_W-1:0] count_q;
   logic             force_ld;
   reload_mode_e     mode;

   assign mode     = reload_mode_e'(force_mode);
   assign force_ld = load_stb && (mode == RELOAD_ON_LOAD);

   div_clamp #(.W(DIV_W), .MIN_DIV(MIN_DIV)) u_clamp (
      .raw_i (div_value),
      .val_o (din_clamped)
   );

   div_shadow #(.W(DIV_W), .RESET_DIV(RESET_DIV)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (load_stb),
      .din_i    (din_clamped),
      .shadow_o (shadow_q),
      .newest_o (newest_val)
   );

   div_counter #(.W(DIV_W), .RESET_DIV(RESET_DIV), .OUT_REG(OUT_REG)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (pd_n),
      .force_i      (force_ld),
      .force_val_i  (din_clamped),
      .reload_val_i (newest_val),
      .count_o      (count_q),
      .tc_o         (tc_pulse)
   );
endmodule

// File: rtl/div_chk.sv
module div_chk #(
   parameter int W       = 11,
   parameter int MIN_DIV = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         pd_n,
   input logic         load_stb,
   input logic         force_mode,
   input logic [W-1:0] div_value,
   input logic [W-1:0] count_q,
   input logic [W-1:0] shadow_q,
   input logic         tc_pulse
);
   localparam logic [W-1:0] MIN_V = W'(MIN_DIV);
   localparam logic [W-1:0] ONE   = W'(1);

   function automatic logic [W-1:0] start_of(input logic [W-1:0] v);
      return ((v < MIN_V) ? MIN_V : v) - ONE;
   endfunction

   p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |=> !tc_pulse);

   p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && !(load_stb && force_mode) && count_q != '0)
      |=> count_q == $past(count_q) - ONE);

   p_force_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && load_stb && force_mode)
      |=> count_q == start_of($past(div_value)));

   p_quiet_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_n && $past(!pd_n)) |-> !tc_pulse);

   p_min_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_q >= MIN_V);
endmodule

bind prog_div div_chk #(.W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_n       (pd_n),
   .load_stb   (load_stb),
   .force_mode (force_mode),
   .div_value  (div_value),
   .count_q    (count_q),
   .shadow_q   (shadow_q),
   .tc_pulse   (tc_pulse)
);

// File: tb/tb_prog_div.sv
module tb_prog_div;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 11;
   localparam int LIMIT      = 5000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pd_n = 1'b1;
   logic [W-1:0] div_value = '0;
   logic         load_stb = 1'b0;
   logic         force_mode = 1'b0;
   logic         tc_pulse;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_div dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .div_value  (div_value),
      .load_stb   (load_stb),
      .force_mode (force_mode),
      .tc_pulse   (tc_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Starts and ends at a falling edge; counts rising edges until the pulse shows.
   task automatic edges_to_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tc_pulse && n < LIMIT);
   endtask

   task automatic step(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic latch(input int v, input bit f);
      div_value  = W'(v);
      force_mode = f;
      load_stb   = 1'b1;
      @(negedge clk);
      load_stb   = 1'b0;
      force_mode = 1'b0;
   endtask

   task automatic t_reset;
      int n;
      check(tc_pulse == 1'b0, "R1 idle", int'(tc_pulse), 0);
      edges_to_pulse(n);
      check(n == 9, "R1 first pulse", n, 9);
      edges_to_pulse(n);
      check(n == 10, "R1 default period", n, 10);
   endtask

   task automatic t_force_small;
      int n;
      latch(7, 1'b1);
      edges_to_pulse(n);
      check(n == 6, "R6 first after force", n, 6);
      edges_to_pulse(n);
      check(n == 7, "R2 period 7", n, 7);
   endtask

   task automatic t_deferred;
      int n;
      step(2);
      latch(12, 1'b0);
      edges_to_pulse(n);
      check(n == 4, "R4 current period kept", n, 4);
      edges_to_pulse(n);
      check(n == 12, "R4 new period", n, 12);
   endtask

   task automatic t_latch_at_zero;
      int n;
      latch(4, 1'b0);
      edges_to_pulse(n);
      check(n == 3, "R10 reload uses same-cycle value", n, 3);
      edges_to_pulse(n);
      check(n == 4, "R10 period 4", n, 4);
   endtask

   task automatic t_two_writes;
      int n;
      step(1);
      latch(9, 1'b0);
      latch(6, 1'b0);
      edges_to_pulse(n);
      check(n == 1, "R5 period end", n, 1);
      edges_to_pulse(n);
      check(n == 6, "R5 last write wins", n, 6);
   endtask

   task automatic t_clamp;
      int n;
      latch(0, 1'b1);
      edges_to_pulse(n);
      check(n == 1, "R7 zero first", n, 1);
      edges_to_pulse(n);
      check(n == 2, "R7 zero as two", n, 2);
      latch(1, 1'b1);
      edges_to_pulse(n);
      check(n == 1, "R7 one first", n, 1);
      edges_to_pulse(n);
      check(n == 2, "R7 one as two", n, 2);
      step(1);
      check(tc_pulse == 1'b0, "R3 single cycle", int'(tc_pulse), 0);
   endtask

   task automatic t_powerdown;
      int n;
      int seen = 0;
      pd_n = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (i == 5) latch(8, 1'b0);
         else @(negedge clk);
         if (tc_pulse) seen++;
      end
      check(seen == 0, "R8 silent in powerdown", seen, 0);
      pd_n = 1'b1;
      edges_to_pulse(n);
      check(n == 7, "R8 restart", n, 7);
      edges_to_pulse(n);
      check(n == 8, "R8 period after release", n, 8);
   endtask

   task automatic t_full;
      int n;
      latch(2047, 1'b1);
      edges_to_pulse(n);
      check(n == 2046, "R9 first", n, 2046);
      edges_to_pulse(n);
      check(n == 2047, "R9 full scale period", n, 2047);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_force_small();
      t_deferred();
      t_latch_at_zero();
      t_two_writes();
      t_clamp();
      t_powerdown();
      t_full();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule